// File: doc/BRIEF.md
# Flash Buffered-Program Command Sequencer

This block is the command front end of a NOR-style flash device for buffered word programming. A host writes a short sequence over a simple write bus. The sequence is a setup code, then a word count, then a run of address/data pairs that fill an internal write buffer, then a confirm code. On a valid confirm the block starts a program engine. The engine reads the buffer through a read port and answers with done and a pass/fail flag. The flash array itself is replaced by that handshake.

The block keeps an 8-bit status register. The ready bit is high whenever the buffer can accept a new sequence and low while the engine runs. Separate sticky bits record sequence errors, program failures and supply lockout. The block checks every data address against the span given by the start address and the count. It limits the span to the buffer size and keeps it inside one erase block. Words that the host never writes read back as all ones, so those locations are left unprogrammed. A clear-status code resets the error bits.

Top module: `flash_bufprog_seq`

## Requirements
- R1: After reset the status output equals 80h (ready only) and `pe_start` is low.
- R2: In the idle state, a write whose low byte is E8h with `vpp_lock` low starts a sequence. The next write is always taken as the count, even when its low byte is a command code such as 70h. The count field is `wr_data[$clog2(BUF_WORDS):0]`, and it holds the number of words minus one.
- R3: The first data write gives the start address S, where N is the word count. It is rejected as a sequence error (status bits 5 and 4 set, back to idle) in any of these cases: N exceeds BUF_WORDS; S is not aligned to a BUF_WORDS boundary, the span crosses such a boundary and N exceeds BUF_WORDS/2; the span crosses an erase-block boundary; or S lies outside the erase block of the setup write.
- R4: Each later data write must address a word in S to S+N-1. Any other address is a sequence error that sets status bits 5 and 4 and returns to idle.
- R5: After exactly N data writes, the next write must be D0h to an address in the setup write's erase block. It raises `pe_start` for one cycle and presents `pe_base` = S and `pe_len` = N. Any other code or block is a sequence error, and the status then reads B0h.
- R6: Through `pe_rd_addr`/`pe_rd_data`, with one cycle of latency, a buffer offset returns the last data written to it during this sequence. An offset that was not written returns FFFFh.
- R7: From `pe_start` until `pe_done`, status bit 7 is 0 and every bus write is ignored. The status value does not change.
- R8: When `pe_done` arrives, ready returns to 1. If `pe_fail` is high, status bit 4 is also set.
- R9: A setup write while `vpp_lock` is high sets status bits 4 and 3 (status 98h from a clear state). The block stays idle and nothing is programmed.
- R10: Status bits 5, 4 and 3 stay set through later sequences until a 50h write arrives in the idle state, which clears them.
- R11: Status bits 6, 2, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Host word address |
| wr_data | input | DATA_W | Host write data; the low byte is the command code |
| vpp_lock | input | 1 | Supply below the programming lockout level |
| status | output | 8 | Status register (7 ready, 5 sequence error, 4 program error, 3 lockout) |
| pe_start | output | 1 | One-cycle start pulse to the program engine |
| pe_base | output | ADDR_W | First array address of the buffered span |
| pe_len | output | $clog2(BUF_WORDS)+2 | Number of words in the span |
| pe_rd_addr | input | $clog2(BUF_WORDS) | Buffer offset the engine reads |
| pe_rd_data | output | DATA_W | Buffer word, one cycle after `pe_rd_addr` |
| pe_done | input | 1 | Engine finished, one-cycle pulse |
| pe_fail | input | 1 | Engine failure flag, valid with `pe_done` |

## Verification
The assertions assume that `pe_done` is pulsed only while the engine is running. They also assume that the host issues at most one write per cycle through `wr_en`. The stimulus keeps to both rules: it raises `pe_done` only after it has seen `pe_start`, and it returns `wr_en` low between writes. The bench runs every start offset in one erase block against every count the field can express, on a configuration with an 8-word buffer and 32-word blocks. The expected accept or reject result and every buffer word are computed arithmetically from the start and count.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_DATA,
    ST_CONFIRM,
    ST_BUSY
  } seq_state_t;

  localparam logic [7:0] OP_SETUP   = 8'hE8;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_CLEAR   = 8'h50;

  localparam int SR_READY = 7;
  localparam int SR_SEQ   = 5;
  localparam int SR_PGM   = 4;
  localparam int SR_LOCK  = 3;
endpackage

// File: rtl/fbp_span_check.sv
module fbp_span_check #(
  parameter int ADDR_W      = 16,
  parameter int BUF_WORDS   = 512,
  parameter int BLOCK_WORDS = 4096,
  parameter int LEN_W       = 11
) (
  input  logic [ADDR_W-1:0]                       probe_addr,
  input  logic [ADDR_W-1:0]                       span_base,
  input  logic [LEN_W-1:0]                        span_len,
  input  logic [ADDR_W-$clog2(BLOCK_WORDS)-1:0]   blk_tag,
  output logic                                    start_bad,
  output logic                                    outside,
  output logic [$clog2(BUF_WORDS)-1:0]            offset
);
  localparam int BUF_W = $clog2(BUF_WORDS);
  localparam int BLK_W = $clog2(BLOCK_WORDS);
  localparam int EXT   = ADDR_W + 2;

  logic [EXT-1:0]    len_x, off_buf, off_blk;
  logic [ADDR_W:0]   diff;
  logic              too_long, mis_cross, blk_cross, foreign;

  assign len_x   = EXT'(span_len);
  assign off_buf = EXT'(probe_addr[BUF_W-1:0]);
  assign off_blk = EXT'(probe_addr[BLK_W-1:0]);

  assign too_long  = len_x > EXT'(BUF_WORDS);
  assign mis_cross = (off_buf != '0) && ((off_buf + len_x) > EXT'(BUF_WORDS))
                     && (len_x > EXT'(BUF_WORDS / 2));
  assign blk_cross = (off_blk + len_x) > EXT'(BLOCK_WORDS);
  assign foreign   = probe_addr[ADDR_W-1:BLK_W] != blk_tag;
  assign start_bad = too_long | mis_cross | blk_cross | foreign;

  assign diff    = {1'b0, probe_addr} - {1'b0, span_base};
  assign outside = diff[ADDR_W] || (diff >= (ADDR_W+1)'(span_len));
  assign offset  = diff[BUF_W-1:0];
endmodule

// File: rtl/fbp_wbuf.sv
module fbp_wbuf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 512
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic [DEPTH-1:0]  written;
  logic              vld_q;

  // Array and registered read kept free of reset so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_mark
      always_ff @(posedge clk) begin
        if (rst || clr)                                  written[i] <= 1'b0;
        else if (we && waddr == ($clog2(DEPTH))'(i))     written[i] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= written[raddr];
  end

  assign rdata = vld_q ? rd_q : '1;
endmodule

// File: rtl/fbp_status.sv
module fbp_status
  import fbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ready_nxt,
  input  logic       clr,
  input  logic       set_seq,
  input  logic       set_pgm,
  input  logic       set_lock,
  output logic [7:0] sr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= 8'h80;
    end else begin
      sr[SR_READY] <= ready_nxt;
      if (clr) begin
        sr[SR_SEQ]  <= 1'b0;
        sr[SR_PGM]  <= 1'b0;
        sr[SR_LOCK] <= 1'b0;
      end
      if (set_seq) begin
        sr[SR_SEQ] <= 1'b1;
        sr[SR_PGM] <= 1'b1;
      end
      if (set_pgm) sr[SR_PGM] <= 1'b1;
      if (set_lock) begin
        sr[SR_PGM]  <= 1'b1;
        sr[SR_LOCK] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_bufprog_seq.sv
module flash_bufprog_seq
  import fbp_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int BUF_WORDS   = 512,
  parameter int BLOCK_WORDS = 4096
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           vpp_lock,
  output logic [7:0]                     status,
  output logic                           pe_start,
  output logic [ADDR_W-1:0]              pe_base,
  output logic [$clog2(BUF_WORDS)+1:0]   pe_len,
  input  logic [$clog2(BUF_WORDS)-1:0]   pe_rd_addr,
  output logic [DATA_W-1:0]              pe_rd_data,
  input  logic                           pe_done,
  input  logic                           pe_fail
);
  localparam int BUF_W = $clog2(BUF_WORDS);
  localparam int BLK_W = $clog2(BLOCK_WORDS);
  localparam int LEN_W = BUF_W + 2;
  localparam int TAG_W = ADDR_W - BLK_W;

  seq_state_t        state, nxt;
  logic [TAG_W-1:0]  blk_tag;
  logic [LEN_W-1:0]  len_q, left_q, count_in;
  logic [ADDR_W-1:0] base_q, span_base;
  logic [7:0]        code;
  logic              first, start_bad, outside;
  logic [BUF_W-1:0]  offset;
  logic              seq_err, lock_err, pgm_err, clr_st, buf_clr, buf_we, go;
  logic              pe_start_q;
  logic              in_idle;

  assign code      = wr_data[7:0];
  assign count_in  = LEN_W'(wr_data[BUF_W:0]) + LEN_W'(1);
  assign first     = (left_q == len_q);
  assign span_base = first ? wr_addr : base_q;
  assign in_idle   = (state == ST_IDLE);

  fbp_span_check #(
    .ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS),
    .BLOCK_WORDS(BLOCK_WORDS), .LEN_W(LEN_W)
  ) u_span (
    .probe_addr(wr_addr), .span_base(span_base), .span_len(len_q),
    .blk_tag(blk_tag), .start_bad(start_bad), .outside(outside),
    .offset(offset)
  );

  always_comb begin
    nxt      = state;
    seq_err  = 1'b0;
    lock_err = 1'b0;
    pgm_err  = 1'b0;
    clr_st   = 1'b0;
    buf_clr  = 1'b0;
    buf_we   = 1'b0;
    go       = 1'b0;
    unique case (state)
      ST_IDLE: if (wr_en) begin
        if (code == OP_SETUP) begin
          if (vpp_lock) lock_err = 1'b1;
          else begin
            nxt     = ST_COUNT;
            buf_clr = 1'b1;
          end
        end else if (code == OP_CLEAR) begin
          clr_st = 1'b1;
        end
      end
      ST_COUNT: if (wr_en) nxt = ST_DATA;
      ST_DATA: if (wr_en) begin
        if (first ? start_bad : outside) begin
          seq_err = 1'b1;
          nxt     = ST_IDLE;
        end else begin
          buf_we = 1'b1;
          if (left_q == LEN_W'(1)) nxt = ST_CONFIRM;
        end
      end
      ST_CONFIRM: if (wr_en) begin
        if (code == OP_CONFIRM && wr_addr[ADDR_W-1:BLK_W] == blk_tag) begin
          go  = 1'b1;
          nxt = ST_BUSY;
        end else begin
          seq_err = 1'b1;
          nxt     = ST_IDLE;
        end
      end
      ST_BUSY: if (pe_done) begin
        pgm_err = pe_fail;
        nxt     = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      pe_start_q <= 1'b0;
      blk_tag    <= '0;
      len_q      <= '0;
      left_q     <= '0;
      base_q     <= '0;
    end else begin
      state      <= nxt;
      pe_start_q <= go;
      if (buf_clr) blk_tag <= wr_addr[ADDR_W-1:BLK_W];
      if (state == ST_COUNT && wr_en) begin
        len_q  <= count_in;
        left_q <= count_in;
      end
      if (buf_we) begin
        if (first) base_q <= wr_addr;
        left_q <= left_q - LEN_W'(1);
      end
    end
  end

  fbp_wbuf #(.DATA_W(DATA_W), .DEPTH(BUF_WORDS)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we), .waddr(offset),
    .wdata(wr_data), .raddr(pe_rd_addr), .rdata(pe_rd_data)
  );

  fbp_status u_sr (
    .clk(clk), .rst(rst), .ready_nxt(nxt != ST_BUSY), .clr(clr_st),
    .set_seq(seq_err), .set_pgm(pgm_err), .set_lock(lock_err), .sr(status)
  );

  assign pe_start = pe_start_q;
  assign pe_base  = base_q;
  assign pe_len   = len_q;
endmodule

// File: rtl/flash_bufprog_chk.sv
module flash_bufprog_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] code,
  input logic       vpp_lock,
  input logic [7:0] status,
  input logic       pe_start,
  input logic       pe_done,
  input logic       idle
);
  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pe_start |=> !pe_start);

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    pe_start |-> !status[7]);

  // R7
  busy_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!status[7] && !pe_done) |=> $stable(status));

  // R9
  lockout_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && wr_en && code == 8'hE8 && vpp_lock) |=> (status[4] && status[3]));

  // R10
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    (status[4] && !(idle && wr_en && code == 8'h50)) |=> status[4]);

  // R10
  sticky_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (status[5] && !(idle && wr_en && code == 8'h50)) |=> status[5]);

  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (status[6] == 1'b0) && (status[2:0] == 3'b000));
endmodule

bind flash_bufprog_seq flash_bufprog_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .code(wr_data[7:0]),
  .vpp_lock(vpp_lock), .status(status), .pe_start(pe_start),
  .pe_done(pe_done), .idle(in_idle)
);

// File: tb/sim_flash_bufprog_seq.sv
`timescale 1ns/100ps
module sim_flash_bufprog_seq;
  localparam int AW = 12, DW = 16, BW = 8, BLK = 32;
  localparam int BUF_W = $clog2(BW);
  localparam int LEN_W = BUF_W + 2;
  localparam int BASE = 32;

  logic             clk = 1'b0, rst = 1'b1;
  logic             wr_en = 1'b0, vpp_lock = 1'b0;
  logic [AW-1:0]    wr_addr = '0;
  logic [DW-1:0]    wr_data = '0;
  logic [7:0]       status;
  logic             pe_start, pe_done = 1'b0, pe_fail = 1'b0;
  logic [AW-1:0]    pe_base;
  logic [LEN_W-1:0] pe_len;
  logic [BUF_W-1:0] pe_rd_addr = '0;
  logic [DW-1:0]    pe_rd_data;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  flash_bufprog_seq #(.ADDR_W(AW), .DATA_W(DW), .BUF_WORDS(BW), .BLOCK_WORDS(BLK)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpp_lock(vpp_lock), .status(status), .pe_start(pe_start), .pe_base(pe_base),
    .pe_len(pe_len), .pe_rd_addr(pe_rd_addr), .pe_rd_data(pe_rd_data),
    .pe_done(pe_done), .pe_fail(pe_fail)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_pe(input logic f);
    @(negedge clk);
    pe_done = 1'b1; pe_fail = f;
    @(negedge clk);
    pe_done = 1'b0; pe_fail = 1'b0;
  endtask

  function automatic int pat(input int s, input int n, input int o);
    return s * 256 + n * 16 + o;
  endfunction

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000 / 2) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset status", status, 8'h80);
    chk("R1 reset start", pe_start, 1'b0);

    // R9 lockout, then R10 sticky through a good program
    vpp_lock = 1'b1;
    bus_wr(BASE, 8'hE8);
    vpp_lock = 1'b0;
    chk("R9 lockout status", status, 8'h98);
    bus_wr(BASE + 1, 16'h1234);
    bus_wr(BASE, 8'hD0);
    chk("R9 nothing started", pe_start, 1'b0);
    chk("R9 still idle", status, 8'h98);
    // R2 count 70h read as N=1
    bus_wr(BASE, 8'hE8);
    bus_wr(BASE, 8'h70);
    bus_wr(BASE + 5, 16'hA5A5);
    bus_wr(BASE, 8'hD0);
    chk("R2 70h taken as count start", pe_start, 1'b1);
    chk("R2 70h taken as count len", pe_len, 1);
    chk("R2 base", pe_base, BASE + 5);
    finish_pe(1'b0);
    chk("R10 sticky after good program", status, 8'h98);
    bus_wr(BASE, 8'h50);
    chk("R10 clear", status, 8'h80);

    // R4 out-of-span addresses
    bus_wr(BASE, 8'hE8); bus_wr(BASE, 3); bus_wr(BASE + 8, 1);
    bus_wr(BASE + 12, 2);
    chk("R4 above span", status, 8'hB0);
    bus_wr(BASE, 8'h50);
    bus_wr(BASE, 8'hE8); bus_wr(BASE, 3); bus_wr(BASE + 8, 1);
    bus_wr(BASE + 7, 2);
    chk("R4 below span", status, 8'hB0);
    bus_wr(BASE, 8'h50);

    // R5 wrong confirm code and wrong block
    bus_wr(BASE, 8'hE8); bus_wr(BASE, 0); bus_wr(BASE + 2, 1);
    bus_wr(BASE, 8'h70);
    chk("R5 wrong confirm code", status, 8'hB0);
    chk("R5 no start on bad code", pe_start, 1'b0);
    bus_wr(BASE, 8'h50);
    bus_wr(BASE, 8'hE8); bus_wr(BASE, 0); bus_wr(BASE + 2, 1);
    bus_wr(BASE + BLK, 8'hD0);
    chk("R5 wrong confirm block", status, 8'hB0);
    bus_wr(BASE, 8'h50);

    // R3 start outside setup block
    bus_wr(BASE, 8'hE8); bus_wr(BASE, 0); bus_wr(BASE + BLK, 1);
    chk("R3 foreign start", status, 8'hB0);

    // Sweep all start offsets and all counts
    for (int s = 0; s < BLK; s++) begin
      for (int n = 1; n <= 16; n++) begin
        bit bad, f;
        int mo;
        bus_wr(BASE, 8'h50);
        chk("R10 clear before run", status, 8'h80);
        bus_wr(BASE, 8'hE8);
        bus_wr(BASE, n - 1);
        bus_wr(BASE + s, pat(s, n, 0));
        mo = s % BW;
        bad = (n > BW) || (mo != 0 && mo + n > BW && n > BW / 2) || (s + n > BLK);
        if (bad) begin
          chk("R3 start rejected", status, 8'hB0);
          continue;
        end
        chk("R3 start accepted", status, 8'h80);
        for (int i = 1; i < n; i++) begin
          if (n >= 3 && i == n - 1) bus_wr(BASE + s + 1, pat(s, n, 1) | 16'h8000);
          else bus_wr(BASE + s + i, pat(s, n, i));
        end
        chk("R4 in-span writes kept ready", status, 8'h80);
        bus_wr(BASE + 3, 8'hD0);
        chk("R5 start pulse", pe_start, 1'b1);
        chk("R5 base", pe_base, BASE + s);
        chk("R5 len", pe_len, n);
        chk("R7 busy on start", status, 8'h00);
        bus_wr(BASE, 8'h50);
        chk("R5 start one cycle", pe_start, 1'b0);
        bus_wr(BASE, 8'hE8);
        chk("R7 writes ignored while busy", status, 8'h00);
        for (int k = 0; k < BW; k++) begin
          int e;
          if (k == 0) e = pat(s, n, 0);
          else if (k >= n) e = 16'hFFFF;
          else if (n >= 3 && k == 1) e = pat(s, n, 1) | 16'h8000;
          else if (n >= 3 && k == n - 1) e = 16'hFFFF;
          else e = pat(s, n, k);
          @(negedge clk);
          pe_rd_addr = BUF_W'(k);
          @(negedge clk);
          chk("R6 buffer word", pe_rd_data, e);
        end
        f = ((s + n) % 5) == 0;
        finish_pe(f);
        chk("R8 done status", status, f ? 8'h90 : 8'h80);
        chk("R11 reserved bits", status & 8'h47, 0);
      end
    end
    summary();
  end
endmodule